// File: doc/BRIEF.md
# Keyboard-style pin event interrupt detector

This block watches a bank of general-purpose input pins (eight by default) and raises one shared interrupt when any enabled pin shows its selected activity. Every pin has its own enable, a polarity choice (falling/low or rising/high) and a choice between pure edge sensitivity and edge-plus-level sensitivity. In edge-plus-level mode the status flag keeps coming back while the pin stays at its active level, so software cannot lose a held key by acknowledging too early.

The pins are asynchronous to the block clock and pass through a two-flop synchronizer before detection. Their edges are taken from the synchronized history alone. Reprogramming a pin therefore never fabricates an edge. A sticky status flag collects the events of all pins. Software clears it by writing an acknowledge bit. The flag drives an interrupt output that software can mask. It also drives an unmasked wake request for the power controller.

Software reaches the block through a small register port with a 2-bit address. Address 0 holds the per-pin enables (1 = watched). Address 1 holds the per-pin mode bits (0 = edge only, 1 = edge plus level). Address 2 holds the per-pin polarity bits (0 = falling edge / low level, 1 = rising edge / high level). Address 3 is control. Its bit 0 is the interrupt enable, which reads back. Bit 1 is the acknowledge: writing 1 clears the flag, and the bit always reads 0. Bit 2 is the read-only status flag. Writes take effect at the clock edge on which the write strobe is high. Reads are combinational from the address.

Top module: `pin_event_irq`

## Requirements
- R1: After reset the enable, mode, polarity and control registers read 0, the status flag is 0, and irq_o and wake_o are 0.
- R2: A pin whose enable bit is 0 never sets the status flag, whatever its mode, polarity or activity.
- R3: In edge-only mode with polarity 0, a high-to-low change on an enabled pin sets the flag. The flag is visible after the third rising clock edge following the pin change and not after the second. A low-to-high change does not set the flag.
- R4: In edge-only mode with polarity 1, a low-to-high change on an enabled pin sets the flag, and a high-to-low change does not.
- R5: In edge-plus-level mode with polarity 0, a falling edge sets the flag. While the pin stays low, an acknowledge clears the flag at its write edge and the flag is set again at the next clock edge. Once the pin is high, an acknowledge clears the flag for good.
- R6: In edge-plus-level mode with polarity 1, the same holds with a rising edge and a high level.
- R7: The flag is sticky. It stays set after the pin returns to its inactive level until an acknowledge (control bit 1 written as 1). In edge-only mode the acknowledge clears it even if the pin is still at the level it moved to.
- R8: irq_o is the flag gated by control bit 0. wake_o is the flag regardless of control bit 0.
- R9: Changing a pin's polarity or mode, or enabling it, while the pin is steady creates no edge event.
- R10: Addresses 0, 1 and 2 read back the last written value. Address 3 reads the interrupt enable in bit 0, 0 in bit 1 and the flag in bit 2.
- R11: An event on any single enabled pin, including the highest-numbered pin, sets the one shared flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | NUM_PINS | Asynchronous pin inputs |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | NUM_PINS | Register write data |
| rdata_o | output | NUM_PINS | Register read data for addr_i |
| irq_o | output | 1 | Masked interrupt request |
| wake_o | output | 1 | Unmasked wake request |

## Verification
If the synchronizer history holds the wrong value, a flag appears when no edge occurred. The same fault can also show as a flag one cycle early or late against the three-edge latency, and the bench sees that within a few cycles of the pin change. A fault in the level path shows in the cycle right after an acknowledge: the flag either fails to return while the pin is held, or it keeps returning after the pin is released. Corrupted configuration or control state shows on the next readback. It also shows as irq_o and wake_o disagreeing with the control bit.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_ENABLE = 2'd0,
        REG_MODE   = 2'd1,
        REG_POLAR  = 2'd2,
        REG_CTRL   = 2'd3
    } reg_addr_e;

    localparam int CTRL_IRQ_EN_BIT = 0;
    localparam int CTRL_ACK_BIT    = 1;
    localparam int CTRL_FLAG_BIT   = 2;
    localparam int CTRL_BITS       = 3;

endpackage

// File: rtl/pin_event_sync.sv
module pin_event_sync #(
    parameter int NUM_PINS = 8,
    parameter int STAGES   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] now_o,
    output logic [NUM_PINS-1:0] prev_o
);

    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][NUM_PINS-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pins_i;
        for (int i = 1; i < DEPTH; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign now_o  = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];

endmodule

// File: rtl/pin_event_cell.sv
module pin_event_cell (
    input  logic now_i,
    input  logic prev_i,
    input  logic enable_i,
    input  logic level_mode_i,
    input  logic polarity_i,
    output logic edge_evt_o,
    output logic level_evt_o
);

    logic rise, fall, edge_hit, at_active;

    always_comb begin
        rise        = now_i & ~prev_i;
        fall        = ~now_i & prev_i;
        edge_hit    = polarity_i ? rise : fall;
        at_active   = polarity_i ? now_i : ~now_i;
        edge_evt_o  = enable_i & edge_hit;
        level_evt_o = enable_i & level_mode_i & at_active;
    end

endmodule

// File: rtl/pin_event_regs.sv
module pin_event_regs
    import pin_event_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    input  logic                flag_i,
    output logic [NUM_PINS-1:0] rdata_o,
    output logic [NUM_PINS-1:0] enable_o,
    output logic [NUM_PINS-1:0] level_mode_o,
    output logic [NUM_PINS-1:0] polarity_o,
    output logic                irq_en_o,
    output logic                ack_o
);

    typedef struct packed {
        logic [NUM_PINS-1:0] enable;
        logic [NUM_PINS-1:0] level_mode;
        logic [NUM_PINS-1:0] polarity;
        logic                irq_en;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    reg_addr_e sel;

    always_comb begin
        sel   = reg_addr_e'(addr_i);
        cfg_d = cfg_q;
        ack_o = 1'b0;
        if (wr_i) begin
            case (sel)
                REG_ENABLE: cfg_d.enable     = wdata_i;
                REG_MODE:   cfg_d.level_mode = wdata_i;
                REG_POLAR:  cfg_d.polarity   = wdata_i;
                default: begin
                    cfg_d.irq_en = wdata_i[CTRL_IRQ_EN_BIT];
                    ack_o        = wdata_i[CTRL_ACK_BIT];
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        case (sel)
            REG_ENABLE: rdata_o = cfg_q.enable;
            REG_MODE:   rdata_o = cfg_q.level_mode;
            REG_POLAR:  rdata_o = cfg_q.polarity;
            default: begin
                rdata_o[CTRL_IRQ_EN_BIT] = cfg_q.irq_en;
                rdata_o[CTRL_FLAG_BIT]   = flag_i;
            end
        endcase
    end

    assign enable_o     = cfg_q.enable;
    assign level_mode_o = cfg_q.level_mode;
    assign polarity_o   = cfg_q.polarity;
    assign irq_en_o     = cfg_q.irq_en;

    // R10: a written register holds its value once the strobe is gone
    p_cfg_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(cfg_q));

endmodule

// File: rtl/pin_event_flag.sv
module pin_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_any_i,
    input  logic level_any_i,
    input  logic ack_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack_i) begin
            st_d.flag = edge_any_i;
        end else if (edge_any_i || level_any_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !edge_any_i) |=> !flag_o);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !ack_i) |=> flag_o);

    p_no_event_no_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !edge_any_i && !level_any_i) |=> !flag_o);

    p_level_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (level_any_i && !ack_i) |=> flag_o);

endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
    import pin_event_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                wr_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [NUM_PINS-1:0] wdata_i,
    output logic [NUM_PINS-1:0] rdata_o,
    output logic                irq_o,
    output logic                wake_o
);

    logic [NUM_PINS-1:0] pin_now, pin_prev;
    logic [NUM_PINS-1:0] enable, level_mode, polarity;
    logic [NUM_PINS-1:0] edge_evt, level_evt;
    logic                irq_en, ack, flag;

    pin_event_sync #(
        .NUM_PINS (NUM_PINS),
        .STAGES   (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (pins_i),
        .now_o  (pin_now),
        .prev_o (pin_prev)
    );

    pin_event_regs #(
        .NUM_PINS (NUM_PINS)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_i         (wr_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .flag_i       (flag),
        .rdata_o      (rdata_o),
        .enable_o     (enable),
        .level_mode_o (level_mode),
        .polarity_o   (polarity),
        .irq_en_o     (irq_en),
        .ack_o        (ack)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        pin_event_cell u_cell (
            .now_i        (pin_now[p]),
            .prev_i       (pin_prev[p]),
            .enable_i     (enable[p]),
            .level_mode_i (level_mode[p]),
            .polarity_i   (polarity[p]),
            .edge_evt_o   (edge_evt[p]),
            .level_evt_o  (level_evt[p])
        );
    end

    pin_event_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .edge_any_i  (|edge_evt),
        .level_any_i (|level_evt),
        .ack_i       (ack),
        .flag_o      (flag)
    );

    assign irq_o  = flag & irq_en;
    assign wake_o = flag;

    p_irq_implies_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> wake_o);

    // R2: disabled pins contribute no event of either kind
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((edge_evt | level_evt) & ~enable) == '0);

endmodule

// File: tb/pin_event_irq_tb.sv
`timescale 1ns/1ps
module pin_event_irq_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pins = '0;
    logic         wr = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [N-1:0] wdata = '0;
    logic [N-1:0] rdata;
    logic         irq, wake;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pin_event_irq #(.NUM_PINS(N)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins),
        .wr_i    (wr),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq),
        .wake_o  (wake)
    );

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(logic [1:0] a, logic [N-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] a, output logic [N-1:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic flag_is(string req, logic exp);
        logic [N-1:0] v;
        rd_reg(2'd3, v);
        check(req, {7'd0, v[2]}, {7'd0, exp});
    endtask

    task automatic ack();
        wr_reg(2'd3, 8'h02);
    endtask

    task automatic clean(logic [N-1:0] level);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd1, 8'h00);
        wr_reg(2'd2, 8'h00);
        pins = level;
        step(4);
        ack();
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        for (int a = 0; a < 4; a++) begin
            rd_reg(a[1:0], v);
            check("R1 register reset", v, 8'h00);
        end
        check("R1 irq reset", {7'd0, irq}, 8'h00);
        check("R1 wake reset", {7'd0, wake}, 8'h00);
    endtask

    task automatic t_disabled();
        clean(8'h00);
        wr_reg(2'd1, 8'hFF);
        wr_reg(2'd2, 8'h0F);
        pins = 8'hFF; step(4);
        pins = 8'h00; step(4);
        flag_is("R2 disabled pins ignored", 1'b0);
    endtask

    task automatic t_fall_edge();
        clean(8'hFF);
        wr_reg(2'd0, 8'h01);
        pins[0] = 1'b0;
        step(2);
        flag_is("R3 not yet after two edges", 1'b0);
        step(1);
        flag_is("R3 set after three edges", 1'b1);
        step(5);
        pins[0] = 1'b1;
        step(4);
        flag_is("R7 sticky after pin returns", 1'b1);
        ack();
        step(4);
        flag_is("R3 rising edge ignored", 1'b0);
        pins[0] = 1'b0;
        step(3);
        ack();
        step(4);
        flag_is("R7 ack clears in edge mode with pin held", 1'b0);
    endtask

    task automatic t_rise_edge();
        clean(8'h00);
        wr_reg(2'd2, 8'h02);
        wr_reg(2'd0, 8'h02);
        pins[1] = 1'b1;
        step(3);
        flag_is("R4 rising edge sets", 1'b1);
        ack();
        pins[1] = 1'b0;
        step(4);
        flag_is("R4 falling edge ignored", 1'b0);
    endtask

    task automatic t_level(logic pol, int p, string tag);
        clean(pol ? 8'h00 : 8'hFF);
        wr_reg(2'd1, 8'h01 << p);
        wr_reg(2'd2, pol ? (8'h01 << p) : 8'h00);
        wr_reg(2'd0, 8'h01 << p);
        pins[p] = pol;
        step(3);
        flag_is({tag, " edge sets"}, 1'b1);
        step(3);
        ack();
        flag_is({tag, " ack clears for one cycle"}, 1'b0);
        step(1);
        flag_is({tag, " level reasserts"}, 1'b1);
        pins[p] = ~pol;
        step(3);
        ack();
        step(3);
        flag_is({tag, " cleared once inactive"}, 1'b0);
    endtask

    task automatic t_gate();
        clean(8'hFF);
        wr_reg(2'd0, 8'h01);
        pins[0] = 1'b0;
        step(3);
        check("R8 irq masked", {7'd0, irq}, 8'h00);
        check("R8 wake unmasked", {7'd0, wake}, 8'h01);
        wr_reg(2'd3, 8'h01);
        check("R8 irq enabled", {7'd0, irq}, 8'h01);
        wr_reg(2'd3, 8'h03);
        check("R8 irq drops on ack", {7'd0, irq}, 8'h00);
        check("R8 wake drops on ack", {7'd0, wake}, 8'h00);
        wr_reg(2'd3, 8'h00);
    endtask

    task automatic t_no_false();
        clean(8'hFF);
        wr_reg(2'd0, 8'h01);
        step(4);
        flag_is("R9 enable on steady pin", 1'b0);
        wr_reg(2'd2, 8'h01);
        step(4);
        flag_is("R9 polarity change on steady pin", 1'b0);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd1, 8'h01);
        step(4);
        flag_is("R9 mode change on inactive level", 1'b0);
    endtask

    task automatic t_readback();
        logic [N-1:0] v;
        clean(8'h00);
        wr_reg(2'd1, 8'h5A); rd_reg(2'd1, v); check("R10 mode readback", v, 8'h5A);
        wr_reg(2'd2, 8'h3C); rd_reg(2'd2, v); check("R10 polarity readback", v, 8'h3C);
        wr_reg(2'd0, 8'hA5); rd_reg(2'd0, v); check("R10 enable readback", v, 8'hA5);
        wr_reg(2'd0, 8'h00);
        wr_reg(2'd3, 8'h03);
        rd_reg(2'd3, v);
        check("R10 control readback", v, 8'h01);
        wr_reg(2'd3, 8'h00);
    endtask

    task automatic t_shared();
        clean(8'hFF);
        wr_reg(2'd0, 8'hFF);
        pins[7] = 1'b0;
        step(3);
        flag_is("R11 top pin sets shared flag", 1'b1);
        pins = 8'hFF;
        step(3);
        ack();
        pins[5] = 1'b0;
        step(3);
        flag_is("R11 middle pin sets shared flag", 1'b1);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_fall_edge();
        t_rise_edge();
        t_level(1'b0, 2, "R5");
        t_level(1'b1, 3, "R6");
        t_gate();
        t_no_false();
        t_readback();
        t_shared();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule